// File: doc/BRIEF.md
# Sliding Neighbourhood Window Generator

This block takes a raster stream of single-plane pixels, one per accepted beat, and for every pixel of the frame presents the square neighbourhood centred on it as one wide output word. Internally it keeps the most recent rows in line buffers and a small register array of the most recent columns. Frame width, frame height, pixel width, window size (3, 5 or 7) and the constant fill value are compile-time parameters. It is meant to feed a rank or convolution stage that needs a full window on each valid cycle.

Where the window reaches past the frame, the missing taps are filled by a policy chosen on the `edge_mode` pin: a fixed constant, a copy of the nearest in-frame pixel, or a reflection about the border that does not repeat the border pixel. The policy is captured once per frame. To finish the last rows and columns, the block steps through virtual border positions on its own after each row and after the final row. It holds `in_ready` low while it does so.

Both stream sides use valid/ready. An input beat transfers on a rising edge where `in_valid` and `in_ready` are both high. An output window transfers on a rising edge where `o_valid` and `o_ready` are both high. While `o_valid` is high and `o_ready` is low, the window and `o_sof` hold still and the whole scan stalls, so no window is lost or repeated.

Top module: `nbhd_window_gen`

## Requirements
- R1: An input pixel transfers only on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is low for the WIN/2 border steps that follow the last pixel of every row, for the WIN/2 border rows that follow the last row, and while an unconsumed window is held at the output.
- R2: While no frame is in progress, `in_ready` is high. Beats with `in_sof` low are accepted and discarded. A beat with `in_sof` high becomes pixel (row 0, column 0). Inside a frame, `in_sof` is ignored and the beat is used as ordinary data.
- R3: Each frame of FRAME_W×FRAME_H input pixels yields exactly FRAME_W×FRAME_H output windows in raster order of their centre pixel. `o_sof` is high only with the window centred on (0,0).
- R4: Window tap (i, j), for i and j from 0 to WIN−1, sits at `o_win[(i*WIN+j)*DW +: DW]` and holds the pixel at row offset i−WIN/2 and column offset j−WIN/2 from the centre. Taps inside the frame carry the input pixel at that position.
- R5: With `edge_mode` 0 or 3 (constant mode), every tap whose row or column lies outside the frame carries the parameter FILL.
- R6: With `edge_mode` 1 (replicate), an outside row or column index is clamped to the nearest valid index, 0 or size−1.
- R7: With `edge_mode` 2 (reflect), an outside index p maps to −p when below zero and to 2·(size−1)−p when at or beyond size, so index −1 takes index 1. Row and column are mapped independently.
- R8: `edge_mode` is sampled on the start-of-frame beat and governs every window of that frame. Later changes take effect only at the next frame.
- R9: While `o_valid` is high and `o_ready` is low, `o_valid`, `o_win` and `o_sof` stay unchanged on the next cycle (unless `ce` is low).
- R10: While `ce` is low, no state changes and both `in_ready` and `o_valid` are low.
- R11: `rst_n` low (asynchronous) or `srst` high on a rising edge (synchronous) abandons any frame in progress. Afterwards `o_valid` is low and the block waits idle for a start-of-frame beat.
- R12: Gaps in `in_valid` of any length within a frame do not change the output windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable, active high |
| edge_mode | input | 2 | Border policy: 0/3 constant, 1 replicate, 2 reflect |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts an input pixel this cycle |
| in_sof | input | 1 | Beat carries pixel (0,0) of a new frame |
| in_data | input | DW | Input pixel |
| o_valid | output | 1 | Output window valid |
| o_ready | input | 1 | Downstream accepts the window this cycle |
| o_sof | output | 1 | Window is centred on pixel (0,0) |
| o_win | output | WIN*WIN*DW | Flattened window, row-major |

## Verification
The embedded properties watch, on every cycle, that a stalled window stays frozen, that the scan enters a frame right after a start-of-frame beat, and that each frame yields the full window count. They also check the left-border cases of each policy: a constant corner tap, a replicated border column, and a reflected tap pair around the centre. Only the bench's scenarios can show that every tap of every window matches the source frame under each policy. The same holds for the per-frame capture of `edge_mode`, the discarding of stray beats while idle, the tolerance of input gaps and clock-enable pauses, and the recovery after a synchronous reset in mid-frame.

// File: rtl/nbhd_pkg.sv
package nbhd_pkg;

  typedef enum logic [1:0] {
    EDGE_CONST     = 2'd0,
    EDGE_REPLICATE = 2'd1,
    EDGE_REFLECT   = 2'd2,
    EDGE_CONST_ALT = 2'd3
  } edge_mode_e;

  typedef struct packed {
    logic       outside;
    logic [3:0] src;
  } tap_sel_t;

  // Maps a window tap index to the window register that supplies it.
  function automatic tap_sel_t pick_tap(input int center, input int tap,
                                        input int radius, input int extent,
                                        input edge_mode_e mode);
    tap_sel_t sel;
    int pos;
    int src;
    pos = center - radius + tap;
    src = tap;
    sel.outside = 1'b0;
    if (pos < 0) begin
      sel.outside = 1'b1;
      if (mode == EDGE_REPLICATE) src = radius - center;
      else if (mode == EDGE_REFLECT) src = 2 * radius - 2 * center - tap;
    end else if (pos > extent - 1) begin
      sel.outside = 1'b1;
      if (mode == EDGE_REPLICATE) src = extent - 1 - center + radius;
      else if (mode == EDGE_REFLECT)
        src = 2 * (extent - 1) - 2 * center + 2 * radius - tap;
    end
    sel.src = 4'(src);
    return sel;
  endfunction

endpackage

// File: rtl/nbhd_linebuf.sv
module nbhd_linebuf #(
  parameter int DW     = 8,
  parameter int LINE_W = 320,
  parameter int NROWS  = 2,
  parameter int AW     = $clog2(LINE_W)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       din,
  output logic [NROWS*DW-1:0] taps
);

  logic [DW-1:0] chain [NROWS+1];
  assign chain[0] = din;

  for (genvar k = 0; k < NROWS; k++) begin : g_row
    logic [DW-1:0] mem [LINE_W];
    assign chain[k+1]          = mem[addr];
    assign taps[k*DW +: DW]    = chain[k+1];
    always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= chain[k];
    end
  end

endmodule

// File: rtl/nbhd_scan.sv
module nbhd_scan
  import nbhd_pkg::*;
#(
  parameter int FRAME_W = 320,
  parameter int FRAME_H = 240,
  parameter int RADIUS  = 1,
  parameter int XW      = $clog2(FRAME_W + RADIUS),
  parameter int YW      = $clog2(FRAME_H + RADIUS),
  parameter int AW      = $clog2(FRAME_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          ce,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          o_ready,
  input  logic [1:0]    mode_in,
  output logic          in_ready,
  output logic          step,
  output logic          lb_wr,
  output logic [AW-1:0] lb_addr,
  output logic          out_vld,
  output logic [XW-1:0] cx,
  output logic [YW-1:0] cy,
  output edge_mode_e    mode_q
);

  localparam int X_LAST = FRAME_W + RADIUS - 1;
  localparam int Y_LAST = FRAME_H + RADIUS - 1;

  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic          active;
  logic          in_frame, adv, at_end, col_real;

  assign col_real = (x < XW'(FRAME_W));
  assign in_frame = col_real && (y < YW'(FRAME_H));
  assign adv      = !out_vld || o_ready;
  assign at_end   = (x == XW'(X_LAST)) && (y == YW'(Y_LAST));
  assign in_ready = ce && adv && (!active || in_frame);
  assign step     = ce && adv &&
                    (active ? (in_frame ? in_valid : 1'b1) : (in_valid && in_sof));
  assign lb_wr    = step && col_real;
  assign lb_addr  = col_real ? x[AW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0; y <= '0; active <= 1'b0; out_vld <= 1'b0;
      cx <= '0; cy <= '0; mode_q <= EDGE_CONST;
    end else if (srst) begin
      x <= '0; y <= '0; active <= 1'b0; out_vld <= 1'b0;
      cx <= '0; cy <= '0; mode_q <= EDGE_CONST;
    end else if (ce) begin
      if (step) begin
        if (!active) mode_q <= edge_mode_e'(mode_in);
        out_vld <= (y >= YW'(RADIUS)) && (x >= XW'(RADIUS));
        cx      <= x - XW'(RADIUS);
        cy      <= y - YW'(RADIUS);
        if (at_end) begin
          x <= '0; y <= '0; active <= 1'b0;
        end else begin
          active <= 1'b1;
          if (x == XW'(X_LAST)) begin
            x <= '0;
            y <= y + 1'b1;
          end else begin
            x <= x + 1'b1;
          end
        end
      end else if (o_ready) begin
        out_vld <= 1'b0;
      end
    end
  end

  // R2: a start-of-frame beat taken while idle opens the frame at column 1
  assert_frame_opens_R2: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (!active && in_valid && in_ready && in_sof) |=> (active && x == XW'(1)))
    else $error("frame did not open after start beat");

endmodule

// File: rtl/nbhd_window.sv
module nbhd_window
  import nbhd_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          WIN     = 3,
  parameter int          FRAME_W = 320,
  parameter int          FRAME_H = 240,
  parameter int          XW      = 9,
  parameter int          YW      = 8,
  parameter logic [DW-1:0] FILL  = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  srst,
  input  logic                  step,
  input  logic [WIN*DW-1:0]     col_in,
  input  logic                  vld,
  input  logic [XW-1:0]         cx,
  input  logic [YW-1:0]         cy,
  input  edge_mode_e            mode,
  output logic [WIN*WIN*DW-1:0] win_out
);

  localparam int RADIUS = (WIN - 1) / 2;
  localparam int IW     = $clog2(WIN);

  logic [DW-1:0] tap_q [WIN][WIN];
  logic          const_mode;

  assign const_mode = (mode == EDGE_CONST) || (mode == EDGE_CONST_ALT);

  always_ff @(posedge clk) begin
    if (step) begin
      for (int i = 0; i < WIN; i++) begin
        for (int j = 0; j < WIN - 1; j++) tap_q[i][j] <= tap_q[i][j+1];
        tap_q[i][WIN-1] <= col_in[i*DW +: DW];
      end
    end
  end

  always_comb begin
    tap_sel_t rs;
    tap_sel_t cs;
    win_out = '0;
    for (int i = 0; i < WIN; i++) begin
      for (int j = 0; j < WIN; j++) begin
        rs = pick_tap(int'(cy), i, RADIUS, FRAME_H, mode);
        cs = pick_tap(int'(cx), j, RADIUS, FRAME_W, mode);
        if (const_mode && (rs.outside || cs.outside))
          win_out[(i*WIN+j)*DW +: DW] = FILL;
        else
          win_out[(i*WIN+j)*DW +: DW] = tap_q[rs.src[IW-1:0]][cs.src[IW-1:0]];
      end
    end
  end

  // R5: corner tap of the first window is the constant in constant mode
  assert_const_corner_R5: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (vld && cx == '0 && cy == '0 && const_mode) |-> (win_out[DW-1:0] == FILL))
    else $error("corner tap not filled with constant");

  // R6: on the left border the outermost tap repeats the border column
  assert_replicate_left_R6: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (vld && cx == '0 && mode == EDGE_REPLICATE) |->
    (win_out[(RADIUS*WIN)*DW +: DW] == win_out[(RADIUS*WIN+RADIUS)*DW +: DW]))
    else $error("replicate border mismatch");

  // R7: on the left border the taps either side of the centre are equal
  assert_reflect_left_R7: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (vld && cx == '0 && mode == EDGE_REFLECT) |->
    (win_out[(RADIUS*WIN+RADIUS-1)*DW +: DW] == win_out[(RADIUS*WIN+RADIUS+1)*DW +: DW]))
    else $error("reflect border mismatch");

endmodule

// File: rtl/nbhd_window_gen.sv
module nbhd_window_gen
  import nbhd_pkg::*;
#(
  parameter int            DW      = 8,
  parameter int            FRAME_W = 320,
  parameter int            FRAME_H = 240,
  parameter int            WIN     = 3,
  parameter logic [DW-1:0] FILL    = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  srst,
  input  logic                  ce,
  input  logic [1:0]            edge_mode,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_sof,
  input  logic [DW-1:0]         in_data,
  output logic                  o_valid,
  input  logic                  o_ready,
  output logic                  o_sof,
  output logic [WIN*WIN*DW-1:0] o_win
);

  localparam int RADIUS = (WIN - 1) / 2;
  localparam int NLINES = WIN - 1;
  localparam int XW     = $clog2(FRAME_W + RADIUS);
  localparam int YW     = $clog2(FRAME_H + RADIUS);
  localparam int AW     = $clog2(FRAME_W);
  localparam int TOTAL  = FRAME_W * FRAME_H;
  localparam int CNTW   = $clog2(TOTAL + 1);

  logic                 step, lb_wr, vld_q;
  logic [AW-1:0]        lb_addr;
  logic [XW-1:0]        cx;
  logic [YW-1:0]        cy;
  edge_mode_e           mode_q;
  logic [NLINES*DW-1:0] line_taps;
  logic [WIN*DW-1:0]    column;

  nbhd_scan #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .RADIUS(RADIUS),
    .XW(XW), .YW(YW), .AW(AW)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce),
    .in_valid(in_valid), .in_sof(in_sof), .o_ready(o_ready), .mode_in(edge_mode),
    .in_ready(in_ready), .step(step), .lb_wr(lb_wr), .lb_addr(lb_addr),
    .out_vld(vld_q), .cx(cx), .cy(cy), .mode_q(mode_q)
  );

  nbhd_linebuf #(
    .DW(DW), .LINE_W(FRAME_W), .NROWS(NLINES), .AW(AW)
  ) u_lines (
    .clk(clk), .wr_en(lb_wr), .addr(lb_addr), .din(in_data), .taps(line_taps)
  );

  // newest row at the bottom of the column, oldest line at the top
  assign column[(WIN-1)*DW +: DW] = in_data;
  for (genvar k = 0; k < NLINES; k++) begin : g_col
    assign column[(WIN-2-k)*DW +: DW] = line_taps[k*DW +: DW];
  end

  nbhd_window #(
    .DW(DW), .WIN(WIN), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
    .XW(XW), .YW(YW), .FILL(FILL)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .srst(srst), .step(step), .col_in(column),
    .vld(vld_q), .cx(cx), .cy(cy), .mode(mode_q), .win_out(o_win)
  );

  assign o_valid = vld_q && ce;
  assign o_sof   = vld_q && ce && (cx == '0) && (cy == '0);

  // R9: a stalled window stays frozen
  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (o_valid && !o_ready) |=> (!ce || (o_valid && $stable(o_win) && $stable(o_sof))))
    else $error("stalled window changed");

  // R3: windows per frame counted against the frame size
  logic [CNTW-1:0] out_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
    end else if (srst) begin
      out_cnt <= '0;
    end else if (o_valid && o_ready) begin
      if (o_sof) begin
        assert_frame_count_R3: assert (out_cnt == '0 || out_cnt == CNTW'(TOTAL))
          else $error("frame ended with wrong window count");
        out_cnt <= CNTW'(1);
      end else begin
        assert_no_excess_R3: assert (out_cnt < CNTW'(TOTAL))
          else $error("more windows than pixels in frame");
        out_cnt <= out_cnt + 1'b1;
      end
    end
  end

endmodule

// File: tb/nbhd_window_gen_test.sv
`timescale 1ns/1ps
module nbhd_window_gen_test;

  localparam int DW = 8;
  localparam int W  = 9;
  localparam int H  = 7;
  localparam int N  = 5;
  localparam int R  = 2;
  localparam int WB = N * N * DW;
  localparam logic [7:0] FILL = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0, srst = 1'b0, ce = 1'b1;
  logic [1:0]    edge_mode = 2'd0;
  logic          in_valid = 1'b0, in_sof = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, o_valid, o_sof;
  logic          o_ready = 1'b1;
  logic [WB-1:0] o_win;

  nbhd_window_gen #(.DW(DW), .FRAME_W(W), .FRAME_H(H), .WIN(N), .FILL(FILL)) uut (
    .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce), .edge_mode(edge_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_data(in_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_sof(o_sof), .o_win(o_win)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int frames_sent = 0, sofs_seen = 0;
  bit bp_en = 0, ce_tog = 0;
  int pix [H][W];
  logic [WB-1:0] exp_q [$];
  bit            sof_q [$];
  string         tag_q [$];

  task automatic chk(input bit ok, input string msg, input logic [WB-1:0] act,
                     input logic [WB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  function automatic int map_ax(int p, int n, int mode);
    if (p >= 0 && p < n) return p;
    if (mode == 1) return (p < 0) ? 0 : n - 1;
    if (mode == 2) return (p < 0) ? -p : 2 * (n - 1) - p;
    return -1;
  endfunction

  function automatic logic [WB-1:0] ref_win(int cy, int cx, int mode);
    logic [WB-1:0] w;
    w = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        int r, c;
        r = map_ax(cy - R + i, H, mode);
        c = map_ax(cx - R + j, W, mode);
        w[(i*N+j)*DW +: DW] = (r < 0 || c < 0) ? FILL : 8'(pix[r][c]);
      end
    end
    return w;
  endfunction

  task automatic gen_frame(input int f, input int mode, input string tag);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        pix[r][c] = (f * 37 + r * 11 + c * 5 + (r * c) % 13) & 8'hFF;
    for (int cy = 0; cy < H; cy++)
      for (int cx = 0; cx < W; cx++) begin
        exp_q.push_back(ref_win(cy, cx, mode));
        sof_q.push_back(cy == 0 && cx == 0);
        tag_q.push_back(tag);
      end
    frames_sent++;
  endtask

  task automatic ready_low(input string msg);
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    chk(!in_ready, msg, in_ready, 0);
  endtask

  task automatic send_frame(input int mode, input bit gaps, input bit sof_glitch,
                            input int mode_after);
    edge_mode = 2'(mode);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        bit acc;
        if (gaps && ((r * W + c) % 4 == 1)) begin
          @(negedge clk);
          in_valid = 1'b0;
        end
        acc = 1'b0;
        while (!acc) begin
          @(negedge clk);
          if (r == 0 && c == 1) edge_mode = 2'(mode_after);  // R8
          in_valid = 1'b1;
          in_data  = 8'(pix[r][c]);
          in_sof   = (r == 0 && c == 0) || (sof_glitch && r == 3 && c == 4);
          #2;
          acc = in_ready;
        end
        if (r == 0 && c == W - 1) ready_low("R1 border step after row");
      end
    end
    ready_low("R1 border rows after frame");
    in_sof = 1'b0;
  endtask

  // output side: drives o_ready and ce, compares every transfer
  logic [WB-1:0] prev_win;
  bit prev_hold = 0;
  always @(negedge clk) begin
    o_ready = bp_en ? ((cyc % 5) != 2) : 1'b1;
    ce      = ce_tog ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (rst_n && !srst) begin
      if (!ce) chk(!in_ready && !o_valid, "R10 ce low blocks both sides",
                   {in_ready, o_valid}, 0);
      if (prev_hold && ce) chk(o_valid && o_win == prev_win, "R9 stalled window held",
                               o_win, prev_win);
      if (o_valid && o_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected window", o_win, 0);
        end else begin
          logic [WB-1:0] e;
          bit s;
          string t;
          e = exp_q.pop_front();
          s = sof_q.pop_front();
          t = tag_q.pop_front();
          chk(o_win == e, {t, " R4 window contents"}, o_win, e);
          chk(o_sof == s, "R3 o_sof position", o_sof, s);
          if (o_sof) sofs_seen++;
        end
      end
      prev_hold = o_valid && !o_ready;
      prev_win  = o_win;
    end else begin
      prev_hold = 0;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog expired", 0, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!o_valid && !o_sof, "R11 outputs idle in reset", {o_valid, o_sof}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(in_ready, "R11 ready after reset", in_ready, 1);

    // stray beats before any start-of-frame are dropped
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = 1'b0;
      in_data  = 8'hEE;
      #2;
      chk(in_ready, "R2 idle accepts stray beat", in_ready, 1);
    end
    @(negedge clk);
    in_valid = 1'b0;

    gen_frame(1, 0, "R5 R2");
    send_frame(0, 0, 0, 0);

    bp_en = 1;
    gen_frame(2, 1, "R6 R12");
    send_frame(1, 1, 0, 1);

    gen_frame(3, 2, "R7 R8 R2");
    send_frame(2, 0, 1, 0);

    ce_tog = 1;
    gen_frame(4, 3, "R5 R10");
    send_frame(3, 1, 0, 3);
    ce_tog = 0;

    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);

    // partial frame then synchronous reset
    for (int k = 0; k < 10; k++) begin
      bit acc;
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (k == 0);
        in_data  = 8'(k * 3);
        #2;
        acc = in_ready;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    srst     = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    #2;
    chk(in_ready && !o_valid, "R11 idle after srst", {in_ready, o_valid}, 2'b10);

    bp_en = 0;
    gen_frame(5, 2, "R7 R11");
    send_frame(2, 1, 0, 2);

    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all windows delivered", exp_q.size(), 0);
    chk(sofs_seen == frames_sent, "R3 one o_sof per frame", sofs_seen, frames_sent);

    summary();
    $finish;
  end

endmodule